// File: doc/BRIEF.md
# Four-Drive Head Positioner with Load/Unload Timing

This block moves the heads of up to four disk drives and times when the shared read/write head is engaged. Each drive has its own present cylinder register and its own step-period timer, so positioning runs on all four drives at once. A seek command names a drive and a target cylinder. The block then emits one-cycle step pulses, with a direction level, spaced by a programmable number of millisecond ticks, until the present cylinder equals the target. A recalibrate command steps a drive outward until its track-zero input is seen, and gives up after a fixed step budget.

Each finished operation becomes a completion event in a small ordered queue. The host sees a pending flag, reads the head event (drive, that drive's present cylinder, equipment-check flag) and pops it with a sense strobe. A drive with a pending or running operation does not accept new commands. Separately, a head timer raises the head-load output when access is requested, reports the head ready once the programmed settle time has elapsed, and holds the head loaded for a programmed idle time after access ends.

Top module: `seek_head_ctrl`

## Requirements
- R1: After reset every present cylinder is 0, no drive is busy, no step pulse is out, no event is pending, and head_load and head_ready are low.
- R2: A seek emits |target - present| step pulses with dir_o high when the target is larger (inward) and low otherwise. Step code k (cfg_step_code, 0..15) gives a step period of k+1 ticks. The first decision is made k+1 ticks after the command is accepted. At each decision point the drive completes if present equals target, and otherwise it steps once and moves the present cylinder by one.
- R3: A seek whose target exceeds 76 is ignored: no steps, no event, present cylinder unchanged.
- R4: Drives position independently and concurrently, each with its own cylinder and timer.
- R5: A command to a drive that is busy, or that has an unread completion event, is ignored.
- R6: Recalibrate steps with dir_o low. At each decision point it completes with the fail flag clear and present cylinder 0 if trk0 of that drive is high.
- R7: If trk0 stays low, recalibrate completes after exactly 77 step pulses, with the fail flag set and the present cylinder unchanged.
- R8: Events leave the queue in completion order. Events completing in the same cycle are queued lowest drive first. int_pending is high while the queue is non-empty. sense_drive, sense_pcn and sense_fail show the oldest event, and sense_rd removes one event.
- R9: sense_rd with an empty queue has no effect.
- R10: Raising rw_req while the head is unloaded sets head_load the next cycle. head_ready follows after 2*c ticks, where c is cfg_load_code (1..127; code 0 acts as 1).
- R11: When rw_req drops, head_ready falls the next cycle and head_load stays high for 16*u ticks, where u is cfg_unload_code (1..15; code 0 acts as 1). If rw_req returns inside that window, head_ready comes back the next cycle with no settle delay.
- R12: Each step pulse lasts one cycle, and dir_o of a busy drive does not change during its operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| cfg_we | input | 1 | Load the three timing codes |
| cfg_step_code | input | 4 | Step period code k (k+1 ticks) |
| cfg_load_code | input | 7 | Head settle code c (2c ticks) |
| cfg_unload_code | input | 4 | Head idle code u (16u ticks) |
| cmd_valid | input | 1 | Command strobe |
| cmd_recal | input | 1 | 1 = recalibrate, 0 = seek |
| cmd_drive | input | 2 | Target drive |
| cmd_cyl | input | 7 | Target cylinder for a seek |
| trk0 | input | 4 | Track-zero sense per drive |
| step_o | output | 4 | Step pulse per drive |
| dir_o | output | 4 | Step direction per drive, 1 = inward |
| int_pending | output | 1 | Completion queue non-empty |
| sense_rd | input | 1 | Pop the oldest completion event |
| sense_drive | output | 2 | Drive of the oldest event |
| sense_pcn | output | 7 | Present cylinder of that drive |
| sense_fail | output | 1 | Equipment check on that event |
| rw_req | input | 1 | Head access requested |
| head_load | output | 1 | Head engaged |
| head_ready | output | 1 | Head settled and usable |

## Verification
The in-line properties assume that ms_tick is a single-cycle strobe with at least one idle cycle between strobes, and that trk0 and rw_req change only between clock edges. The bench produces the tick every fourth cycle from its own divider. It issues commands, head requests and head drops only in the cycle right after a tick, so no accept or head transition shares an edge with a tick, and tick counts between events are exact. trk0 is raised only after the bench has counted the intended number of step pulses, which keeps the recalibrate decision points predictable.

// File: rtl/seek_head_ctrl.sv
module seek_head_ctrl #(
  parameter int DRIVES      = 4,
  parameter int CW          = 7,
  parameter int CYL_MAX     = 76,
  parameter int RECAL_STEPS = 77
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ms_tick,
  input  logic                       cfg_we,
  input  logic [3:0]                 cfg_step_code,
  input  logic [6:0]                 cfg_load_code,
  input  logic [3:0]                 cfg_unload_code,
  input  logic                       cmd_valid,
  input  logic                       cmd_recal,
  input  logic [$clog2(DRIVES)-1:0]  cmd_drive,
  input  logic [CW-1:0]              cmd_cyl,
  input  logic [DRIVES-1:0]          trk0,
  output logic [DRIVES-1:0]          step_o,
  output logic [DRIVES-1:0]          dir_o,
  output logic                       int_pending,
  input  logic                       sense_rd,
  output logic [$clog2(DRIVES)-1:0]  sense_drive,
  output logic [CW-1:0]              sense_pcn,
  output logic                       sense_fail,
  input  logic                       rw_req,
  output logic                       head_load,
  output logic                       head_ready
);
  localparam int DW  = $clog2(DRIVES);
  localparam int QCW = $clog2(DRIVES + 1);
  localparam int SW  = $clog2(RECAL_STEPS + 1);

  typedef enum logic [1:0] {H_IDLE, H_LOAD, H_UP, H_HOLD} head_st_t;

  logic [3:0]    step_code;
  logic [6:0]    load_code;
  logic [3:0]    unload_code;

  logic [CW-1:0] pcn [DRIVES];
  logic [CW-1:0] ncn [DRIVES];
  logic [4:0]    tmr [DRIVES];
  logic [SW-1:0] nst [DRIVES];
  logic [DRIVES-1:0] busy, recal, pend;

  logic [DRIVES-1:0] accept, slot, dok, dfail, done, fire;
  logic [DW-1:0]     wslot [DRIVES];
  logic [QCW-1:0]    pushes;

  logic [DW-1:0]  q_drv  [DRIVES];
  logic           q_fail [DRIVES];
  logic [DW-1:0]  rd_ptr, wr_ptr;
  logic [QCW-1:0] q_cnt;
  logic           pop;

  head_st_t  hst;
  logic [7:0] hcnt;

  wire [4:0] reload    = {1'b0, step_code} + 5'd1;
  wire [7:0] load_ms   = {(load_code == 7'd0) ? 7'd1 : load_code, 1'b0};
  wire [7:0] unload_ms = {(unload_code == 4'd0) ? 4'd1 : unload_code, 4'b0000};

  always_comb begin
    for (int d = 0; d < DRIVES; d++) begin
      accept[d] = cmd_valid && (cmd_drive == DW'(d)) && !busy[d] && !pend[d] &&
                  (cmd_recal || (cmd_cyl <= CW'(CYL_MAX)));
      slot[d]   = busy[d] && ms_tick && (tmr[d] == 5'd1);
      dok[d]    = slot[d] && (recal[d] ? trk0[d] : (pcn[d] == ncn[d]));
      dfail[d]  = slot[d] && recal[d] && !trk0[d] && (nst[d] == SW'(RECAL_STEPS));
      done[d]   = dok[d] || dfail[d];
      fire[d]   = slot[d] && !done[d];
    end
  end

  always_comb begin
    pushes = '0;
    for (int d = 0; d < DRIVES; d++) begin
      wslot[d] = wr_ptr + DW'(pushes);
      pushes   = pushes + QCW'(done[d]);
    end
  end

  assign pop         = sense_rd && (q_cnt != '0);
  assign int_pending = (q_cnt != '0);
  assign sense_drive = q_drv[rd_ptr];
  assign sense_fail  = q_fail[rd_ptr];
  assign sense_pcn   = pcn[sense_drive];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_code   <= '0;
      load_code   <= 7'd1;
      unload_code <= 4'd1;
    end else if (cfg_we) begin
      step_code   <= cfg_step_code;
      load_code   <= cfg_load_code;
      unload_code <= cfg_unload_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= '0;
      recal  <= '0;
      pend   <= '0;
      step_o <= '0;
      dir_o  <= '0;
      for (int d = 0; d < DRIVES; d++) begin
        pcn[d] <= '0;
        ncn[d] <= '0;
        tmr[d] <= '0;
        nst[d] <= '0;
      end
    end else begin
      for (int d = 0; d < DRIVES; d++) begin
        step_o[d] <= fire[d];
        if (accept[d]) begin
          busy[d]  <= 1'b1;
          recal[d] <= cmd_recal;
          ncn[d]   <= cmd_recal ? '0 : cmd_cyl;
          dir_o[d] <= !cmd_recal && (cmd_cyl > pcn[d]);
          tmr[d]   <= reload;
          nst[d]   <= '0;
        end else if (busy[d] && ms_tick) begin
          tmr[d] <= (tmr[d] == 5'd1) ? reload : tmr[d] - 5'd1;
          if (done[d]) begin
            busy[d] <= 1'b0;
            pend[d] <= 1'b1;
            if (dok[d] && recal[d]) pcn[d] <= '0;
          end
          if (fire[d]) begin
            nst[d] <= nst[d] + SW'(1);
            if (!recal[d]) pcn[d] <= dir_o[d] ? pcn[d] + CW'(1) : pcn[d] - CW'(1);
          end
        end
        if (pop && (q_drv[rd_ptr] == DW'(d))) pend[d] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      q_cnt  <= '0;
      for (int d = 0; d < DRIVES; d++) begin
        q_drv[d]  <= '0;
        q_fail[d] <= 1'b0;
      end
    end else begin
      for (int d = 0; d < DRIVES; d++) begin
        if (done[d]) begin
          q_drv[wslot[d]]  <= DW'(d);
          q_fail[wslot[d]] <= dfail[d];
        end
      end
      wr_ptr <= wr_ptr + DW'(pushes);
      rd_ptr <= rd_ptr + DW'(pop);
      q_cnt  <= q_cnt + pushes - QCW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hst  <= H_IDLE;
      hcnt <= '0;
    end else begin
      case (hst)
        H_IDLE: if (rw_req) begin hst <= H_LOAD; hcnt <= load_ms; end
        H_LOAD: if (ms_tick) begin
                  if (hcnt == 8'd1) hst <= H_UP;
                  else hcnt <= hcnt - 8'd1;
                end
        H_UP:   if (!rw_req) begin hst <= H_HOLD; hcnt <= unload_ms; end
        H_HOLD: if (rw_req) hst <= H_UP;
                else if (ms_tick) begin
                  if (hcnt == 8'd1) hst <= H_IDLE;
                  else hcnt <= hcnt - 8'd1;
                end
        default: hst <= H_IDLE;
      endcase
    end
  end

  assign head_load  = (hst != H_IDLE);
  assign head_ready = (hst == H_UP);

  for (genvar g = 0; g < DRIVES; g++) begin : g_chk
    a_r12_step_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      step_o[g] |=> !step_o[g]);
    a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      step_o[g] |-> $past(ms_tick));
    a_r12_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && $past(busy[g])) |-> $stable(dir_o[g]));
    a_r3_pcn_range: assert property (@(posedge clk) disable iff (!rst_n)
      pcn[g] <= CW'(CYL_MAX));
    a_r5_pend_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend[g] && busy[g]));
  end

  a_r8_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QCW'(DRIVES));
  a_r10_ready_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(head_ready) |-> $past(head_load));
endmodule

// File: tb/test_seek_head_ctrl.sv
module test_seek_head_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_PER   = 4;
  localparam int WDOG       = 150000;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_step_code = '0;
  logic [6:0] cfg_load_code = '0;
  logic [3:0] cfg_unload_code = '0;
  logic cmd_valid = 1'b0, cmd_recal = 1'b0;
  logic [1:0] cmd_drive = '0;
  logic [6:0] cmd_cyl = '0;
  logic [3:0] trk0 = '0;
  logic [3:0] step_o, dir_o;
  logic int_pending, sense_fail, head_load, head_ready;
  logic sense_rd = 1'b0;
  logic [1:0] sense_drive;
  logic [6:0] sense_pcn;

  seek_head_ctrl i_seek_head_ctrl (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .cfg_we(cfg_we), .cfg_step_code(cfg_step_code), .cfg_load_code(cfg_load_code),
    .cfg_unload_code(cfg_unload_code),
    .cmd_valid(cmd_valid), .cmd_recal(cmd_recal), .cmd_drive(cmd_drive), .cmd_cyl(cmd_cyl),
    .trk0(trk0), .step_o(step_o), .dir_o(dir_o),
    .int_pending(int_pending), .sense_rd(sense_rd), .sense_drive(sense_drive),
    .sense_pcn(sense_pcn), .sense_fail(sense_fail),
    .rw_req(rw_req), .head_load(head_load), .head_ready(head_ready)
  );

  logic rw_req = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv    <= (tdiv == TICK_PER-1) ? 0 : tdiv + 1;
    ms_tick <= (tdiv == TICK_PER-1);
  end

  int tick_cnt = 0;
  always @(posedge clk) if (ms_tick) tick_cnt <= tick_cnt + 1;

  int scnt [4] = '{0, 0, 0, 0};
  logic [3:0] sdir = '0;
  always @(negedge clk)
    for (int d = 0; d < 4; d++)
      if (step_o[d]) begin scnt[d] <= scnt[d] + 1; sdir[d] <= dir_o[d]; end

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WDOG && !finished) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic after_tick();
    @(posedge clk);
    while (!ms_tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int sc, input int lc, input int uc);
    @(negedge clk);
    cfg_we = 1; cfg_step_code = 4'(sc); cfg_load_code = 7'(lc); cfg_unload_code = 4'(uc);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic put_cmd(input int drv, input bit rc, input int cyl);
    cmd_valid = 1; cmd_drive = 2'(drv); cmd_recal = rc; cmd_cyl = 7'(cyl);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic issue(input int drv, input bit rc, input int cyl);
    after_tick();
    put_cmd(drv, rc, cyl);
  endtask

  task automatic wait_int(input string req);
    int n = 0;
    while (!int_pending && n < 20000) begin @(negedge clk); n++; end
    chk(req, int'(int_pending), 1);
  endtask

  task automatic pop();
    sense_rd = 1;
    @(negedge clk);
    sense_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {target cylinder, expected steps, expected dir} for drive 0, step code 0
  localparam logic [14:0] VEC [6] = '{
    {7'd10, 7'd10, 1'b1},
    {7'd3,  7'd7,  1'b0},
    {7'd3,  7'd0,  1'b0},
    {7'd76, 7'd73, 1'b1},
    {7'd0,  7'd76, 1'b0},
    {7'd41, 7'd41, 1'b1}
  };

  initial begin
    int b0, b1, b2, b3, t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 step_o", int'(step_o), 0);
    chk("R1 int_pending", int'(int_pending), 0);
    chk("R1 head_load", int'(head_load), 0);
    chk("R1 head_ready", int'(head_ready), 0);
    rst_n = 1;
    cfg(0, 3, 2);

    // R2 R12 table of seeks on drive 0
    for (int i = 0; i < 6; i++) begin
      b0 = scnt[0];
      issue(0, 0, int'(VEC[i][14:8]));
      wait_int("R2 completion");
      chk("R2 steps", scnt[0] - b0, int'(VEC[i][7:1]));
      if (VEC[i][7:1] != 0) chk("R2 R12 dir", int'(sdir[0]), int'(VEC[i][0]));
      chk("R8 sense_drive", int'(sense_drive), 0);
      chk("R2 sense_pcn", int'(sense_pcn), int'(VEC[i][14:8]));
      chk("R2 sense_fail", int'(sense_fail), 0);
      pop();
      chk("R8 popped", int'(int_pending), 0);
    end

    // R3 out-of-range target ignored
    b1 = scnt[1];
    issue(1, 0, 90);
    idle(200);
    chk("R3 no event", int'(int_pending), 0);
    chk("R3 no steps", scnt[1] - b1, 0);
    issue(1, 0, 5);
    wait_int("R3 follow-up");
    chk("R3 pcn kept 0", scnt[1] - b1, 5);
    chk("R3 pcn", int'(sense_pcn), 5);
    pop();

    // R4 R5 R8 parallel seeks, busy and pending drives ignore commands
    b2 = scnt[2]; b3 = scnt[3];
    after_tick();
    put_cmd(2, 0, 20);
    put_cmd(3, 0, 5);
    issue(2, 0, 60);
    wait_int("R4 first");
    chk("R8 order first drive", int'(sense_drive), 3);
    chk("R4 drive3 pcn", int'(sense_pcn), 5);
    issue(3, 0, 70);
    pop();
    wait_int("R4 second");
    chk("R8 order second drive", int'(sense_drive), 2);
    chk("R5 busy cmd ignored pcn", int'(sense_pcn), 20);
    pop();
    idle(300);
    chk("R5 pending cmd ignored", int'(int_pending), 0);
    chk("R5 drive3 steps", scnt[3] - b3, 5);
    chk("R4 drive2 steps", scnt[2] - b2, 20);

    // R8 simultaneous completion: lowest drive first
    after_tick();
    put_cmd(1, 0, 8);
    put_cmd(0, 0, 44);
    wait_int("R8 simultaneous");
    chk("R8 same-cycle first", int'(sense_drive), 0);
    chk("R8 first pcn", int'(sense_pcn), 44);
    pop();
    chk("R8 second present", int'(int_pending), 1);
    chk("R8 same-cycle second", int'(sense_drive), 1);
    chk("R8 second pcn", int'(sense_pcn), 8);
    pop();
    chk("R8 drained", int'(int_pending), 0);

    // R9 read on empty queue
    pop();
    chk("R9 still empty", int'(int_pending), 0);
    issue(0, 0, 45);
    wait_int("R9 next event");
    chk("R9 drive", int'(sense_drive), 0);
    chk("R9 pcn", int'(sense_pcn), 45);
    pop();
    chk("R9 single event", int'(int_pending), 0);

    // R6 recalibrate finds track zero after 5 steps
    b0 = scnt[0];
    issue(0, 1, 0);
    while (scnt[0] - b0 < 5) @(negedge clk);
    trk0[0] = 1;
    wait_int("R6 completion");
    chk("R6 steps", scnt[0] - b0, 5);
    chk("R6 dir outward", int'(sdir[0]), 0);
    chk("R6 fail clear", int'(sense_fail), 0);
    chk("R6 pcn zero", int'(sense_pcn), 0);
    pop();
    trk0[0] = 0;

    // R7 recalibrate without track zero
    b1 = scnt[1];
    issue(1, 1, 0);
    wait_int("R7 completion");
    chk("R7 steps", scnt[1] - b1, 77);
    chk("R7 fail set", int'(sense_fail), 1);
    chk("R7 pcn unchanged", int'(sense_pcn), 8);
    pop();

    // R2 step spacing with code 2 (3 ticks)
    cfg(2, 3, 2);
    b2 = scnt[2];
    issue(2, 0, 23);
    t0 = tick_cnt;
    for (int s = 1; s <= 3; s++) begin
      while (scnt[2] - b2 < s) @(negedge clk);
      chk("R2 step spacing", tick_cnt - t0, 3 * s);
    end
    wait_int("R2 spacing completion");
    chk("R2 completion tick", tick_cnt - t0, 12);
    chk("R2 pcn 23", int'(sense_pcn), 23);
    pop();

    // R10 head load with code 3 (6 ticks)
    after_tick();
    rw_req = 1;
    t0 = tick_cnt;
    @(negedge clk);
    chk("R10 head_load", int'(head_load), 1);
    chk("R10 not ready yet", int'(head_ready), 0);
    while (!head_ready) @(negedge clk);
    chk("R10 settle ticks", tick_cnt - t0, 6);

    // R11 drop and return inside window, then full unload (code 2 = 32 ticks)
    after_tick();
    rw_req = 0;
    @(negedge clk);
    chk("R11 ready drops", int'(head_ready), 0);
    chk("R11 still loaded", int'(head_load), 1);
    idle(40);
    after_tick();
    rw_req = 1;
    @(negedge clk);
    chk("R11 ready returns", int'(head_ready), 1);
    after_tick();
    rw_req = 0;
    t0 = tick_cnt;
    while (head_load) @(negedge clk);
    chk("R11 unload ticks", tick_cnt - t0, 32);

    // R10 code 0 acts as 1 (2 ticks)
    cfg(2, 0, 2);
    after_tick();
    rw_req = 1;
    t0 = tick_cnt;
    @(negedge clk);
    while (!head_ready) @(negedge clk);
    chk("R10 code zero ticks", tick_cnt - t0, 2);
    rw_req = 0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule